// File: doc/BRIEF.md
# Byte-to-Word SRAM Fetch Sequencer

This block builds a 32-bit word out of four back-to-back reads of an asynchronous SRAM that is 8 bits wide. A requester gives a byte address and pulses start. The sequencer drives the SRAM address and holds it for a programmable number of cycles. It then captures the data bus and moves on to the next byte. When the word is complete it returns the word together with a one-cycle done pulse.

Two address orders are supported: descending from base+3 and ascending from base. In both orders the k-th byte read goes into byte lane k of the result. A per-request wait-state field matches the hold time to the speed grade of the SRAM. A single-byte mode fetches one byte and zero-extends it.

The block keeps its own running address. Each request either loads a new base or continues from the stored address. A word fetch moves the stored address forward by 4 and a byte fetch moves it forward by 1. This lets code be streamed without resending the address.

Top module: `sram_word_fetch`

## Requirements
- R1: A word fetch (word_mode=1) performs exactly four byte reads from consecutive SRAM addresses. Between two reads of the same fetch, sram_addr changes by exactly 1.
- R2: With count_down=1, a word fetch first drives base+3 and then steps down by 1 for each read. The k-th read (k=0..3) lands in result bits 8k+7:8k, so base+3 is in bits 7:0 and base is in bits 31:24.
- R3: With count_down=0, a word fetch reads base, base+1, base+2, base+3 in that order. The k-th read lands in bits 8k+7:8k, so base is in bits 7:0.
- R4: sram_addr is updated on the start edge and on each capture edge. After any change it holds for at least two cycles, which leaves at least one full idle cycle before the data bus is captured.
- R5: wait_sel (W, 0..3) is sampled with start. Each byte takes 2+W cycles. done rises N*(2+W) cycles after the start edge, where N=4 for a word and N=1 for a byte.
- R6: With word_mode=0, one byte is read from the base address, whatever count_down is. The result is that byte in bits 7:0 with bits 31:8 zero.
- R7: use_addr=1 takes base_addr as the base. use_addr=0 takes the stored address. On completion the stored address becomes base+4 for a word or base+1 for a byte, modulo 2^ADDR_W, and is shown on next_addr.
- R8: done is high for exactly one cycle per accepted request. result changes only in the cycle where done is high, and it holds until the next completion.
- R9: A start asserted while a fetch is in progress is ignored. It produces no done, no extra SRAM reads and no change to the stored address.
- R10: After synchronous reset, done=0, result=0, next_addr=0 and sram_addr=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, accepted only when idle |
| word_mode | input | 1 | 1 = four-byte word fetch, 0 = single byte |
| count_down | input | 1 | 1 = descending address order for word fetch |
| wait_sel | input | 2 | Extra wait cycles per byte |
| use_addr | input | 1 | 1 = use base_addr, 0 = continue from stored address |
| base_addr | input | ADDR_W | Byte base address of the request |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Assembled word or zero-extended byte |
| next_addr | output | ADDR_W | Stored running address |
| sram_addr | output | ADDR_W | SRAM address bus |
| sram_data | input | 8 | SRAM data bus |

## Verification
Completion is due exactly N*(2+W) cycles after the start edge, with N=4 for a word and N=1 for a byte. The driver records the cycle number of the start edge and stores the expected due cycle with the expected word and next address. The monitor compares against these on the falling edge in the cycle where done is high. The SRAM model returns garbage until an address has been stable across one whole cycle, so a capture made too early shows up as a wrong byte as well as a wrong cycle. The stability of result and the ignored-start cases are checked several cycles after completion, at the block's own outputs.

// File: rtl/sfq_pkg.sv
package sfq_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } sfq_state_t;
endpackage

// File: rtl/sfq_wait_timer.sv
module sfq_wait_timer #(
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WAIT_W-1:0] waits,
  input  logic              run,
  output logic              fire
);
  localparam int CNT_W = WAIT_W + 1;

  logic [CNT_W-1:0]  cnt;
  logic [WAIT_W-1:0] waits_q;

  assign fire = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      waits_q <= '0;
    end else if (load) begin
      waits_q <= waits;
      cnt     <= {1'b0, waits} + CNT_W'(1);
    end else if (run) begin
      if (cnt == '0) cnt <= {1'b0, waits_q} + CNT_W'(1);
      else           cnt <= cnt - CNT_W'(1);
    end
  end
endmodule

// File: rtl/sfq_addr_gen.sv
module sfq_addr_gen #(
  parameter int ADDR_W = 16,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic              word,
  input  logic              down,
  input  logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] TOP_OFS = ADDR_W'(LANES - 1);

  logic down_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr   <= '0;
      down_q <= 1'b0;
    end else if (load) begin
      down_q <= down;
      addr   <= (word && down) ? base + TOP_OFS : base;
    end else if (step) begin
      addr <= down_q ? addr - ADDR_W'(1) : addr + ADDR_W'(1);
    end
  end
endmodule

// File: rtl/sfq_byte_asm.sv
module sfq_byte_asm #(
  parameter int DATA_W = 8,
  parameter int LANES  = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clear,
  input  logic                      shift,
  input  logic [DATA_W-1:0]         din,
  output logic [DATA_W*LANES-1:0]   nxt
);
  localparam int HOLD_W = DATA_W * (LANES - 1);

  logic [HOLD_W-1:0] hold_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == LANES - 1) begin : g_top
      assign nxt[g*DATA_W +: DATA_W] = din;
    end else begin : g_low
      assign nxt[g*DATA_W +: DATA_W] = hold_q[g*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) hold_q <= '0;
    else if (shift)   hold_q <= nxt[DATA_W*LANES-1:DATA_W];
  end
endmodule

// File: rtl/sram_word_fetch.sv
module sram_word_fetch
  import sfq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int LANES  = 4,
  parameter int WAIT_W = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic                    word_mode,
  input  logic                    count_down,
  input  logic [WAIT_W-1:0]       wait_sel,
  input  logic                    use_addr,
  input  logic [ADDR_W-1:0]       base_addr,
  output logic                    done,
  output logic [DATA_W*LANES-1:0] result,
  output logic [ADDR_W-1:0]       next_addr,
  output logic [ADDR_W-1:0]       sram_addr,
  input  logic [DATA_W-1:0]       sram_data
);
  localparam int WORD_W = DATA_W * LANES;
  localparam int IDX_W  = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(LANES - 1);
  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(LANES);
  localparam logic [ADDR_W-1:0] BYTE_STEP = ADDR_W'(1);

  sfq_state_t        state;
  logic              word_q;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] stored;
  logic              busy;
  logic              launch;
  logic              fire;
  logic              last;
  logic              step;
  logic [ADDR_W-1:0] eff_base;
  logic [WORD_W-1:0] asm_nxt;
  logic [WORD_W-1:0] zext;

  assign busy     = (state == ST_BUSY);
  assign launch   = (state == ST_IDLE) && start;
  assign eff_base = use_addr ? base_addr : stored;
  assign last     = word_q ? (idx == LAST_IDX) : 1'b1;
  assign step     = fire && !last;
  assign zext     = {{(WORD_W - DATA_W){1'b0}}, sram_data};
  assign next_addr = stored;

  sfq_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .load  (launch),
    .waits (wait_sel),
    .run   (busy),
    .fire  (fire)
  );

  sfq_addr_gen #(.ADDR_W(ADDR_W), .LANES(LANES)) u_addr (
    .clk  (clk),
    .rst  (rst),
    .load (launch),
    .step (step),
    .word (word_mode),
    .down (count_down),
    .base (eff_base),
    .addr (sram_addr)
  );

  sfq_byte_asm #(.DATA_W(DATA_W), .LANES(LANES)) u_asm (
    .clk   (clk),
    .rst   (rst),
    .clear (launch),
    .shift (fire && word_q),
    .din   (sram_data),
    .nxt   (asm_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      word_q <= 1'b0;
      idx    <= '0;
      base_q <= '0;
      stored <= '0;
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state  <= ST_BUSY;
            word_q <= word_mode;
            base_q <= eff_base;
            idx    <= '0;
          end
        end
        ST_BUSY: begin
          if (fire) begin
            if (last) begin
              done   <= 1'b1;
              result <= word_q ? asm_nxt : zext;
              stored <= base_q + (word_q ? WORD_STEP : BYTE_STEP);
              state  <= ST_IDLE;
            end else begin
              idx <= idx + IDX_W'(1);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sfq_checker.sv
module sfq_checker #(
  parameter int ADDR_W = 16,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              done,
  input logic              busy,
  input logic [WORD_W-1:0] result,
  input logic [ADDR_W-1:0] sram_addr
);
  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_result_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(result) |-> done);

  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(sram_addr) |=> $stable(sram_addr));

  assert_addr_step_R1: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sram_addr) && $past(busy)) |->
      ((sram_addr == $past(sram_addr) + ADDR_W'(1)) ||
       (sram_addr == $past(sram_addr) - ADDR_W'(1))));

  assert_done_from_busy_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));
endmodule

bind sram_word_fetch sfq_checker #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .done      (done),
  .busy      (busy),
  .result    (result),
  .sram_addr (sram_addr)
);

// File: tb/tb_sram_word_fetch.sv
module tb_sram_word_fetch;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          word_mode = 1'b0;
  logic          count_down = 1'b0;
  logic [1:0]    wait_sel = 2'd0;
  logic          use_addr = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic          done;
  logic [31:0]   result;
  logic [AW-1:0] next_addr;
  logic [AW-1:0] sram_addr;
  logic [7:0]    sram_data;

  sram_word_fetch dut (
    .clk(clk), .rst(rst), .start(start), .word_mode(word_mode),
    .count_down(count_down), .wait_sel(wait_sel), .use_addr(use_addr),
    .base_addr(base_addr), .done(done), .result(result),
    .next_addr(next_addr), .sram_addr(sram_addr), .sram_data(sram_data)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] pat(input logic [AW-1:0] a);
    return (a[7:0] * 8'd7) + a[15:8] + 8'h11;
  endfunction

  // SRAM model: data valid only once the address has been stable across a full cycle
  logic [AW-1:0] last_addr = '0;
  always @(posedge clk) last_addr <= sram_addr;
  assign sram_data = (sram_addr == last_addr) ? pat(sram_addr) : 8'hEE;

  typedef struct {
    logic [31:0]   word;
    logic [AW-1:0] nxt;
    int            due;
    string         tag;
  } exp_t;
  exp_t q[$];

  logic [AW-1:0] model_stored = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Driver: computes expectation, pushes it, pulses start
  task automatic fetch(input bit wm, input bit dn, input logic [1:0] w,
                       input bit ua, input logic [AW-1:0] ba, input string tag);
    exp_t e;
    logic [AW-1:0] b;
    int n;
    b = ua ? ba : model_stored;
    n = wm ? 4 : 1;
    if (!wm) e.word = {24'h0, pat(b)};
    else if (dn) e.word = {pat(b), pat(b + 16'd1), pat(b + 16'd2), pat(b + 16'd3)};
    else         e.word = {pat(b + 16'd3), pat(b + 16'd2), pat(b + 16'd1), pat(b)};
    e.nxt = b + (wm ? 16'd4 : 16'd1);
    model_stored = e.nxt;
    e.tag = tag;
    @(negedge clk);
    start = 1'b1; word_mode = wm; count_down = dn; wait_sel = w;
    use_addr = ua; base_addr = ba;
    @(posedge clk);
    #1;
    e.due = cyc + n * (2 + int'(w));
    q.push_back(e);
    @(negedge clk);
    start = 1'b0;
    repeat (n * (2 + int'(w)) + 2) @(negedge clk);
  endtask

  // Monitor: scoreboard compare at the falling edge
  logic prev_done = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (done && prev_done) chk(1'b0, "R8 done longer than one cycle", 32'd1, 32'd0);
      if (done) begin
        if (q.size() == 0) begin
          chk(1'b0, "R9 unexpected done", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(result == e.word, {e.tag, " result"}, result, e.word);
          chk(cyc == e.due, {e.tag, " R5 done cycle"}, 32'(cyc), 32'(e.due));
          chk(next_addr == e.nxt, {e.tag, " R7 next_addr"}, 32'(next_addr), 32'(e.nxt));
        end
      end
    end
    prev_done = done;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(done == 1'b0, "R10 done", 32'(done), 32'd0);
    chk(result == 32'h0, "R10 result", result, 32'h0);
    chk(next_addr == '0, "R10 next_addr", 32'(next_addr), 32'h0);
    chk(sram_addr == '0, "R10 sram_addr", 32'(sram_addr), 32'h0);

    fetch(1'b1, 1'b1, 2'd0, 1'b1, 16'h0100, "R2 R1 down W0");
    fetch(1'b1, 1'b0, 2'd1, 1'b1, 16'h0200, "R3 up W1");
    fetch(1'b1, 1'b0, 2'd3, 1'b0, 16'hDEAD, "R7 R3 continue W3");
    fetch(1'b0, 1'b0, 2'd2, 1'b0, 16'h0000, "R6 byte W2");
    fetch(1'b0, 1'b1, 2'd0, 1'b0, 16'h0000, "R6 byte down W0");
    fetch(1'b1, 1'b1, 2'd2, 1'b0, 16'h0000, "R2 R4 down W2");
    fetch(1'b1, 1'b0, 2'd1, 1'b1, 16'hFFFE, "R7 R3 wrap");
    fetch(1'b1, 1'b1, 2'd3, 1'b1, 16'hFFFD, "R2 wrap down");

    // R9: second start during a fetch is ignored
    begin
      exp_t e;
      logic [AW-1:0] b;
      b = 16'h0400;
      e.word = {pat(b + 16'd3), pat(b + 16'd2), pat(b + 16'd1), pat(b)};
      e.nxt = b + 16'd4;
      e.tag = "R9 ignored start";
      model_stored = e.nxt;
      @(negedge clk);
      start = 1'b1; word_mode = 1'b1; count_down = 1'b0; wait_sel = 2'd1;
      use_addr = 1'b1; base_addr = b;
      @(posedge clk);
      #1;
      e.due = cyc + 12;
      q.push_back(e);
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      start = 1'b1; word_mode = 1'b0; use_addr = 1'b1; base_addr = 16'h7777; wait_sel = 2'd0;
      @(negedge clk);
      start = 1'b0;
      repeat (14) @(negedge clk);
      chk(q.size() == 0, "R9 queue drained", 32'(q.size()), 32'd0);
      chk(next_addr == 16'h0404, "R9 stored address untouched", 32'(next_addr), 32'h0404);
    end

    // R8: result held long after completion
    repeat (6) @(negedge clk);
    chk(result == {pat(16'h0403), pat(16'h0402), pat(16'h0401), pat(16'h0400)},
        "R8 result held", result,
        {pat(16'h0403), pat(16'h0402), pat(16'h0401), pat(16'h0400)});
    chk(done == 1'b0, "R8 done low when idle", 32'(done), 32'd0);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule